// File: doc/BRIEF.md
# Time-Slot Switch Processor Access Port

This block sits between a host microprocessor and the storage of a time-slot interchange switch that carries 8 serial streams of 32 channels each. It holds one 8-bit mode register and three 256-byte stores: a data store holding the samples received from the streams, a low connection store and a high connection store. The host reaches them through a 6-bit parallel address with read and write strobes and an acknowledge. When address bit 5 is clear the host reaches the mode register. Otherwise the low five address bits pick one of 32 channels, and the mode register picks the store and the stream whose 32-entry section is used.

Only a write to the mode register finishes at once. Every other access waits for an arbitration slot that the switch side signals on a strobe input. The acknowledge then rises and stays up, with read data held, until the host drops its strobe. The switch side has its own port. It writes received samples into the data store, and it reads back both connection bytes for any stream and channel. On that read, a global message bit can force two bits of the high byte, gated by an output-drive-enable input.

Top module: `tsi_ctrl_port`

## Requirements
- R1: After reset the mode register reads 0x00, every entry of all three stores reads 0x00, and the acknowledge is low.
- R2: With address bit 5 at 0, the access reaches the mode register whatever bits 4..0 hold. A write there is acknowledged on the cycle after the strobe is first seen, without waiting for an arbitration slot.
- R3: Mode register layout: bit 7 split, bit 6 message, bit 5 unused and always read as 0, bits 4:3 store select, bits 2:0 stream.
- R4: Any access other than a mode-register write is granted only on a clock edge where the arbitration strobe is 1 and a host strobe is held. The acknowledge rises on the cycle after the grant and stays low before it.
- R5: Once raised, the acknowledge and the read data stay unchanged while a host strobe is held. The acknowledge falls on the cycle after both strobes are low.
- R6: With split at 0, store select 01 picks the data store, 10 the low connection store and 11 the high connection store. The entry index is stream*32 + address bits 4..0.
- R7: With split at 0 and store select 00, a read returns 0x00 and a write changes no store.
- R8: Host writes to the data store are ignored. The data store is written only by the switch-side write port, at entry stream*32 + channel.
- R9: With split at 1, reads come from the data store and writes go to the low connection store, whatever the store select holds.
- R10: The switch-side read port presents the low and high connection bytes of entry stream*32 + channel on the cycle after the address is applied.
- R11: When the message bit is 1 and output-drive-enable is 1, the switch-side high byte shows bits 2 and 0 as 1. The stored byte is not changed, and host reads return it unmodified. Otherwise the stored high byte is shown as it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 6 | Host address; bit 5 selects store space, bits 4..0 channel |
| cpu_wdata | input | 8 | Host write data |
| cpu_rd | input | 1 | Host read strobe, held until acknowledge |
| cpu_wr | input | 1 | Host write strobe, held until acknowledge |
| cpu_rdata | output | 8 | Host read data, held while acknowledge is high |
| cpu_ack | output | 1 | Access acknowledge |
| arb_slot | input | 1 | Switch-side arbitration slot for slow accesses |
| sw_wr_en | input | 1 | Switch-side data store write enable |
| sw_wr_stream | input | 3 | Switch-side write stream |
| sw_wr_chan | input | 5 | Switch-side write channel |
| sw_wr_data | input | 8 | Switch-side write data |
| sw_rd_stream | input | 3 | Switch-side connection read stream |
| sw_rd_chan | input | 5 | Switch-side connection read channel |
| sw_ode | input | 1 | Output drive enable, gates the message override |
| sw_cml | output | 8 | Low connection byte, registered |
| sw_cmh | output | 8 | High connection byte with override, registered |

## Verification
The hardest state to reach is split mode combined with a store select that points elsewhere, which has to be followed by a switch-side read of the same entry. That read is the only place a redirected write becomes visible. The bench models the mode register and all three stores and draws random mixes of mode writes, host accesses, data-store fills and switch reads, so split, message and select-00 states recur with stale entries behind them. Directed steps first set up one entry in each store so that each redirection and the gated override land on a known value.

// File: rtl/tsi_pkg.sv
// Package tsi_pkg
// Shared constants and types for the time-slot switch access port.
// Assumes an 8-bit mode register with the bit positions given below.
package tsi_pkg;
    localparam int MODE_SPLIT  = 7;
    localparam int MODE_MSG    = 6;
    localparam int MODE_UNUSED = 5;
    localparam int MODE_SEL_HI = 4;
    localparam int MODE_SEL_LO = 3;

    typedef enum logic [1:0] {
        SEL_NONE = 2'b00,
        SEL_DM   = 2'b01,
        SEL_CML  = 2'b10,
        SEL_CMH  = 2'b11
    } store_sel_e;

    typedef enum logic {
        ACC_IDLE = 1'b0,
        ACC_DONE = 1'b1
    } acc_state_e;
endpackage

// File: rtl/tsi_store.sv
// Module tsi_store
// Flop-based byte store with one write port and RD_PORTS asynchronous
// read ports. Every entry is cleared on synchronous reset.
// Assumes DEPTH is a power of two and small enough to hold in flops.
module tsi_store #(
    parameter int DEPTH    = 256,
    parameter int DW       = 8,
    parameter int RD_PORTS = 1,
    localparam int AW      = $clog2(DEPTH)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [AW-1:0]                  waddr,
    input  logic [DW-1:0]                  wdata,
    input  logic [RD_PORTS-1:0][AW-1:0]    raddr,
    output logic [RD_PORTS-1:0][DW-1:0]    rdata
);
    logic [DW-1:0] mem [DEPTH];

    // Clear on reset, otherwise write one entry when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // One combinational read per port.
    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        assign rdata[p] = mem[raddr[p]];
    end
endmodule

// File: rtl/tsi_access_fsm.sv
// Module tsi_access_fsm
// Host-side access controller: owns the mode register, decodes each host
// access to a store and entry, and runs the strobe/acknowledge handshake.
// Assumes the host holds one strobe until acknowledge and then drops it;
// if both strobes are high the access is treated as a write.
module tsi_access_fsm
    import tsi_pkg::*;
#(
    parameter int SW = 3,
    parameter int CW = 5,
    parameter int DW = 8,
    localparam int IW = SW + CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW:0]   cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    input  logic          cpu_rd,
    input  logic          cpu_wr,
    input  logic          arb_slot,
    output logic [DW-1:0] cpu_rdata,
    output logic          cpu_ack,
    output logic [IW-1:0] mem_idx,
    output logic          wr_cml,
    output logic          wr_cmh,
    output logic          msg_mode,
    input  logic [DW-1:0] dm_rd,
    input  logic [DW-1:0] cml_rd,
    input  logic [DW-1:0] cmh_rd
);
    acc_state_e    state_q;
    logic [DW-1:0] mode_q;
    logic [DW-1:0] rdata_q;
    logic          is_mode;
    logic          strobe;
    logic          fast_wr;
    logic          grant;
    store_sel_e    sel;
    store_sel_e    rd_sel;
    store_sel_e    wr_sel;
    logic [DW-1:0] rd_val;

    // Address decode and store routing from the mode register.
    always_comb begin
        is_mode = !cpu_addr[CW];
        strobe  = cpu_rd || cpu_wr;
        fast_wr = cpu_wr && is_mode;
        sel     = store_sel_e'(mode_q[MODE_SEL_HI:MODE_SEL_LO]);
        rd_sel  = mode_q[MODE_SPLIT] ? SEL_DM  : sel;
        wr_sel  = mode_q[MODE_SPLIT] ? SEL_CML : sel;
        mem_idx = {mode_q[SW-1:0], cpu_addr[CW-1:0]};
        grant   = (state_q == ACC_IDLE) && strobe && (arb_slot || fast_wr);
    end

    // Store write enables; a data store target never writes.
    always_comb begin
        wr_cml = grant && cpu_wr && !is_mode && (wr_sel == SEL_CML);
        wr_cmh = grant && cpu_wr && !is_mode && (wr_sel == SEL_CMH);
    end

    // Read data source for the current access.
    always_comb begin
        if (is_mode) begin
            rd_val = mode_q;
        end else begin
            case (rd_sel)
                SEL_DM:  rd_val = dm_rd;
                SEL_CML: rd_val = cml_rd;
                SEL_CMH: rd_val = cmh_rd;
                default: rd_val = '0;
            endcase
        end
    end

    // Handshake state, mode register and held read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ACC_IDLE;
            mode_q  <= '0;
            rdata_q <= '0;
        end else begin
            case (state_q)
                ACC_IDLE: begin
                    if (grant) begin
                        state_q <= ACC_DONE;
                        if (fast_wr) begin
                            mode_q <= cpu_wdata & ~(DW'(1) << MODE_UNUSED);
                        end
                        if (!cpu_wr) begin
                            rdata_q <= rd_val;
                        end
                    end
                end
                default: begin
                    if (!strobe) begin
                        state_q <= ACC_IDLE;
                    end
                end
            endcase
        end
    end

    assign cpu_ack   = (state_q == ACC_DONE);
    assign cpu_rdata = rdata_q;
    assign msg_mode  = mode_q[MODE_MSG];

    // R2
    fast_mode_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_ack && cpu_wr && !cpu_addr[CW]) |=> cpu_ack);

    // R4
    grant_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_ack) |-> ($past(arb_slot) || ($past(cpu_wr) && !$past(cpu_addr[CW]))));

    // R5
    ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && (cpu_rd || cpu_wr)) |=> (cpu_ack && $stable(cpu_rdata)));

    // R5
    ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && !cpu_rd && !cpu_wr) |=> !cpu_ack);
endmodule

// File: rtl/tsi_ctrl_port.sv
// Module tsi_ctrl_port
// Top of the time-slot switch access port: host access controller, the
// data store (written by the switch side) and the two connection stores
// (written by the host, read by both sides). The switch-side connection
// read is registered and applies the message override to the high byte.
// Assumes the stream field of the mode register is at most 3 bits wide.
module tsi_ctrl_port #(
    parameter int STREAMS  = 8,
    parameter int CHANNELS = 32,
    parameter int DW       = 8,
    localparam int SW      = $clog2(STREAMS),
    localparam int CW      = $clog2(CHANNELS),
    localparam int IW      = SW + CW,
    localparam int DEPTH   = STREAMS * CHANNELS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW:0]   cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    input  logic          cpu_rd,
    input  logic          cpu_wr,
    output logic [DW-1:0] cpu_rdata,
    output logic          cpu_ack,
    input  logic          arb_slot,
    input  logic          sw_wr_en,
    input  logic [SW-1:0] sw_wr_stream,
    input  logic [CW-1:0] sw_wr_chan,
    input  logic [DW-1:0] sw_wr_data,
    input  logic [SW-1:0] sw_rd_stream,
    input  logic [CW-1:0] sw_rd_chan,
    input  logic          sw_ode,
    output logic [DW-1:0] sw_cml,
    output logic [DW-1:0] sw_cmh
);
    localparam logic [DW-1:0] MSG_FORCE = DW'(5);

    logic [IW-1:0]        mem_idx;
    logic [IW-1:0]        sw_idx;
    logic                 wr_cml;
    logic                 wr_cmh;
    logic                 msg_mode;
    logic [0:0][DW-1:0]   dm_rd;
    logic [1:0][DW-1:0]   cml_rd;
    logic [1:0][DW-1:0]   cmh_rd;
    logic [DW-1:0]        sw_cml_q;
    logic [DW-1:0]        sw_cmh_q;

    assign sw_idx = {sw_rd_stream, sw_rd_chan};

    tsi_access_fsm #(.SW(SW), .CW(CW), .DW(DW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_rd    (cpu_rd),
        .cpu_wr    (cpu_wr),
        .arb_slot  (arb_slot),
        .cpu_rdata (cpu_rdata),
        .cpu_ack   (cpu_ack),
        .mem_idx   (mem_idx),
        .wr_cml    (wr_cml),
        .wr_cmh    (wr_cmh),
        .msg_mode  (msg_mode),
        .dm_rd     (dm_rd[0]),
        .cml_rd    (cml_rd[0]),
        .cmh_rd    (cmh_rd[0])
    );

    tsi_store #(.DEPTH(DEPTH), .DW(DW), .RD_PORTS(1)) u_dm (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (sw_wr_en),
        .waddr ({sw_wr_stream, sw_wr_chan}),
        .wdata (sw_wr_data),
        .raddr (mem_idx),
        .rdata (dm_rd)
    );

    tsi_store #(.DEPTH(DEPTH), .DW(DW), .RD_PORTS(2)) u_cml (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_cml),
        .waddr (mem_idx),
        .wdata (cpu_wdata),
        .raddr ({sw_idx, mem_idx}),
        .rdata (cml_rd)
    );

    tsi_store #(.DEPTH(DEPTH), .DW(DW), .RD_PORTS(2)) u_cmh (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_cmh),
        .waddr (mem_idx),
        .wdata (cpu_wdata),
        .raddr ({sw_idx, mem_idx}),
        .rdata (cmh_rd)
    );

    // Register the switch-side view, forcing the message bits when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_cml_q <= '0;
            sw_cmh_q <= '0;
        end else begin
            sw_cml_q <= cml_rd[1];
            sw_cmh_q <= cmh_rd[1] | ((msg_mode && sw_ode) ? MSG_FORCE : '0);
        end
    end

    assign sw_cml = sw_cml_q;
    assign sw_cmh = sw_cmh_q;

    // R11
    msg_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(msg_mode) && $past(sw_ode)) |-> (sw_cmh[2] && sw_cmh[0]));
endmodule

// File: tb/sim_tsi_ctrl_port.sv
module sim_tsi_ctrl_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0;
    logic       cpu_rd = 1'b0;
    logic       cpu_wr = 1'b0;
    logic [7:0] cpu_rdata;
    logic       cpu_ack;
    logic       arb_slot = 1'b0;
    logic       sw_wr_en = 1'b0;
    logic [2:0] sw_wr_stream = '0;
    logic [4:0] sw_wr_chan = '0;
    logic [7:0] sw_wr_data = '0;
    logic [2:0] sw_rd_stream = '0;
    logic [4:0] sw_rd_chan = '0;
    logic       sw_ode = 1'b0;
    logic [7:0] sw_cml;
    logic [7:0] sw_cmh;

    int n_chk = 0;
    int n_err = 0;

    logic [7:0] mode_m;
    logic [7:0] dm_m  [256];
    logic [7:0] cml_m [256];
    logic [7:0] cmh_m [256];

    always #2.5 clk = ~clk;

    tsi_ctrl_port u0 (
        .clk(clk), .rst_n(rst_n),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack), .arb_slot(arb_slot),
        .sw_wr_en(sw_wr_en), .sw_wr_stream(sw_wr_stream), .sw_wr_chan(sw_wr_chan),
        .sw_wr_data(sw_wr_data), .sw_rd_stream(sw_rd_stream), .sw_rd_chan(sw_rd_chan),
        .sw_ode(sw_ode), .sw_cml(sw_cml), .sw_cmh(sw_cmh)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Expected host read value from the model (R3, R6, R7, R9).
    function automatic logic [7:0] exp_read(input logic [5:0] a);
        logic [7:0] idx;
        idx = {mode_m[2:0], a[4:0]};
        if (!a[5]) return mode_m;
        if (mode_m[7]) return dm_m[idx];
        case (mode_m[4:3])
            2'b01:   return dm_m[idx];
            2'b10:   return cml_m[idx];
            2'b11:   return cmh_m[idx];
            default: return 8'h00;
        endcase
    endfunction

    // Model effect of a host write (R3, R7, R8, R9).
    task automatic model_write(input logic [5:0] a, input logic [7:0] d);
        logic [7:0] idx;
        idx = {mode_m[2:0], a[4:0]};
        if (!a[5]) mode_m = d & 8'hDF;
        else if (mode_m[7]) cml_m[idx] = d;
        else if (mode_m[4:3] == 2'b10) cml_m[idx] = d;
        else if (mode_m[4:3] == 2'b11) cmh_m[idx] = d;
    endtask

    // Host access with handshake checks (R2, R4, R5).
    task automatic cpu_xfer(input bit wr, input logic [5:0] a, input logic [7:0] d,
                            input int wait_n, input int hold_n);
        logic [7:0] exp;
        logic [7:0] got;
        bit fast;
        fast = wr && !a[5];
        exp = exp_read(a);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = wr; cpu_rd = !wr; arb_slot = 1'b0;
        if (!fast) begin
            for (int i = 0; i < wait_n; i++) begin
                @(negedge clk);
                chk("R4 ack before slot", {7'd0, cpu_ack}, 8'd0);
            end
            arb_slot = 1'b1;
            @(negedge clk);
            arb_slot = 1'b0;
            chk("R4 ack after grant", {7'd0, cpu_ack}, 8'd1);
        end else begin
            @(negedge clk);
            chk("R2 fast mode write ack", {7'd0, cpu_ack}, 8'd1);
        end
        got = cpu_rdata;
        if (!wr) chk(a[5] ? "R6 read data" : "R3 mode readback", got, exp);
        for (int i = 0; i < hold_n; i++) begin
            @(negedge clk);
            chk("R5 ack held", {7'd0, cpu_ack}, 8'd1);
            chk("R5 data held", cpu_rdata, got);
        end
        cpu_rd = 1'b0; cpu_wr = 1'b0;
        @(negedge clk);
        chk("R5 ack released", {7'd0, cpu_ack}, 8'd0);
        if (wr) model_write(a, d);
    endtask

    // Switch-side data store write (R8).
    task automatic sw_write(input logic [2:0] s, input logic [4:0] c, input logic [7:0] d);
        @(negedge clk);
        sw_wr_en = 1'b1; sw_wr_stream = s; sw_wr_chan = c; sw_wr_data = d;
        @(negedge clk);
        sw_wr_en = 1'b0;
        dm_m[{s, c}] = d;
    endtask

    // Switch-side connection read (R10, R11).
    task automatic sw_read(input logic [2:0] s, input logic [4:0] c, input bit ode);
        logic [7:0] eh;
        @(negedge clk);
        sw_rd_stream = s; sw_rd_chan = c; sw_ode = ode;
        @(negedge clk);
        eh = cmh_m[{s, c}] | ((mode_m[6] && ode) ? 8'h05 : 8'h00);
        chk("R10 low byte", sw_cml, cml_m[{s, c}]);
        chk("R11 high byte view", sw_cmh, eh);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        mode_m = 8'h00;
        for (int i = 0; i < 256; i++) begin
            dm_m[i] = 8'h00; cml_m[i] = 8'h00; cmh_m[i] = 8'h00;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ack low", {7'd0, cpu_ack}, 8'd0);
        cpu_xfer(1'b0, 6'h15, 8'h00, 1, 0);
        sw_read(3'd7, 5'd31, 1'b1);
        sw_read(3'd0, 5'd0, 1'b0);
        // R3 unused bit reads 0, R2 any low address reaches the register
        cpu_xfer(1'b1, 6'h0A, 8'hFF, 0, 1);
        cpu_xfer(1'b0, 6'h1F, 8'h00, 2, 1);
        // R6 low and high connection stores, stream 3 channel 5
        cpu_xfer(1'b1, 6'h00, 8'h13, 0, 0);
        cpu_xfer(1'b1, 6'h25, 8'hA5, 1, 0);
        cpu_xfer(1'b0, 6'h25, 8'h00, 0, 2);
        cpu_xfer(1'b1, 6'h07, 8'h1B, 0, 0);
        cpu_xfer(1'b1, 6'h25, 8'h3C, 3, 0);
        cpu_xfer(1'b0, 6'h25, 8'h00, 0, 0);
        sw_read(3'd3, 5'd5, 1'b1);
        // R8 host write to data store ignored
        sw_write(3'd2, 5'd7, 8'h77);
        cpu_xfer(1'b1, 6'h00, 8'h0A, 0, 0);
        cpu_xfer(1'b1, 6'h27, 8'h11, 1, 0);
        cpu_xfer(1'b0, 6'h27, 8'h00, 1, 0);
        // R7 select 00
        cpu_xfer(1'b1, 6'h00, 8'h03, 0, 0);
        cpu_xfer(1'b1, 6'h25, 8'hEE, 0, 0);
        cpu_xfer(1'b0, 6'h25, 8'h00, 0, 0);
        sw_read(3'd3, 5'd5, 1'b0);
        // R9 split with select pointing at high store
        cpu_xfer(1'b1, 6'h00, 8'h9A, 0, 0);
        cpu_xfer(1'b1, 6'h27, 8'h42, 2, 0);
        cpu_xfer(1'b0, 6'h27, 8'h00, 0, 1);
        sw_read(3'd2, 5'd7, 1'b1);
        // R11 message override gated by drive enable, store unchanged
        cpu_xfer(1'b1, 6'h00, 8'h5B, 0, 0);
        sw_read(3'd3, 5'd5, 1'b1);
        sw_read(3'd3, 5'd5, 1'b0);
        cpu_xfer(1'b0, 6'h25, 8'h00, 1, 0);
        // Random mix
        for (int k = 0; k < 500; k++) begin
            int op;
            op = $urandom % 6;
            case (op)
                0: cpu_xfer(1'b1, {1'b0, 5'($urandom)}, 8'($urandom), 0, $urandom % 3);
                1: cpu_xfer(1'b0, {1'b1, 5'($urandom)}, 8'h00, $urandom % 4, $urandom % 3);
                2: cpu_xfer(1'b0, 6'($urandom), 8'h00, $urandom % 4, $urandom % 3);
                3: cpu_xfer(1'b1, {1'b1, 5'($urandom)}, 8'($urandom), $urandom % 4, $urandom % 3);
                4: sw_write(3'($urandom), 5'($urandom), 8'($urandom));
                default: sw_read(3'($urandom), 5'($urandom), 1'($urandom));
            endcase
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule